// File: doc/BRIEF.md
# Multi-Chain Muxed Scan Register Wrapper

This block holds a parameterized bank of design flops and puts a two-way selector in front of each one. While the test-mode input is low, every flop loads its bit of the functional data bus on each clock edge, and the bank behaves as an ordinary register. While test-mode is high, the same flops are joined into several parallel shift registers. Each shift register has its own serial input and output. A tester fills all of them at once and reads back the captured state on the same clock edges.

The flops are dealt out across the chains in turn: flop i goes to chain i mod NUM_CHAINS. Every chain has the same length, ceil(NUM_FLOPS / NUM_CHAINS). A chain that has fewer real flops is filled up at its serial-input end with dummy slots. Because of this, a bit needs the same number of shift edges to cross any chain. The block also passes on a set of output-enable requests for bidirectional pads. Test mode forces all of these enables off, so shifting cannot toggle the pad drivers.

Top module: `scan_wrap`

## Requirements
- R1: While testMode is 0 and rst is 0, each rising clock edge loads funcD into the flop bank. funcQ[i] then shows funcD[i] as it was at that edge, and scanIn has no effect.
- R2: While testMode is 1 and rst is 0, each rising edge shifts every chain by one place toward its scanOut. The scan-in-end slot of chain c takes scanIn[c]. funcD has no effect.
- R3: Flop i belongs to chain i mod NUM_CHAINS and sits floor(i / NUM_CHAINS) places from that chain's scan-out end. A value held in flop i therefore appears on scanOut[i mod NUM_CHAINS] after floor(i / NUM_CHAINS) shift edges.
- R4: scanOut[c] always shows the flop at the scan-out end of chain c, which is flop c. Right after a functional capture, that value can be read as soon as testMode rises, before any shift edge. The k-th shift edge then brings flop k*NUM_CHAINS + c to scanOut[c], or a dummy slot if that index is NUM_FLOPS or more.
- R5: All chains are CHAIN_LEN = ceil(NUM_FLOPS / NUM_CHAINS) slots long. Dummy slots sit at the scan-in end and load 0 on a functional capture. A bit presented on scanIn of any chain reaches scanOut on exactly the CHAIN_LEN-th shift edge.
- R6: Any pattern can be loaded with CHAIN_LEN shift edges. On shift edge k (counting from 0), scanIn[c] should carry the wanted value of flop k*NUM_CHAINS + c. After the last of these edges, funcQ shows the whole pattern.
- R7: padOe equals padOeReq while testMode is 0 and is all zero while testMode is 1. This path has no clock delay.
- R8: Reset is synchronous. An edge with rst high clears every flop, dummy slots included, in either mode, and it wins over both shifting and capture.
- R9: Unloading the old state and loading the new pattern happen on the same shift edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all flops |
| rst | input | 1 | Synchronous clear, active high |
| testMode | input | 1 | 1 = shift mode, 0 = functional capture |
| scanIn | input | NUM_CHAINS | Serial input, one bit per chain |
| scanOut | output | NUM_CHAINS | Serial output, one bit per chain |
| funcD | input | NUM_FLOPS | Functional next-state bus |
| funcQ | output | NUM_FLOPS | Current flop contents |
| padOeReq | input | NUM_PADS | Requested bidirectional pad output enables |
| padOe | output | NUM_PADS | Gated pad output enables |

## Verification
Two functions can meet on one edge. The first pair is synchronous reset and a shift: the bench raises rst while testMode is high and every scanIn is 1, and it expects funcQ and scanOut to be all zero after that edge rather than shifted. The second pair is unload and load: each shift edge both moves out a bit of the old captured state and takes in a bit of the new pattern. The bench checks every scanOut bit against the old pattern after each edge, and then checks funcQ against the new pattern after the last edge. The pad gate is checked against the requests both in functional mode and while a shift is in progress.

// File: rtl/scan_wrap_pkg.sv
package scan_wrap_pkg;

  // Strobes from the mode control to the flop bank and the pad gate.
  typedef struct packed {
    logic clear;    // synchronous clear, highest priority
    logic shift;    // serial path selected
    logic capture;  // functional path selected
    logic padKill;  // force all pad enables off
  } scanStrobe_t;

endpackage

// File: rtl/scan_mode_ctrl.sv
module scan_mode_ctrl
  import scan_wrap_pkg::*;
(
  input  logic        rst,
  input  logic        testMode,
  output scanStrobe_t strobe
);

  always_comb begin
    strobe.clear   = rst;
    strobe.shift   = !rst && testMode;
    strobe.capture = !rst && !testMode;
    strobe.padKill = testMode;
  end

endmodule

// File: rtl/scan_cell.sv
module scan_cell
  import scan_wrap_pkg::*;
(
  input  logic        clk,
  input  scanStrobe_t strobe,
  input  logic        funcIn,
  input  logic        serialIn,
  output logic        q
);

  always_ff @(posedge clk) begin
    if (strobe.clear)        q <= 1'b0;
    else if (strobe.shift)   q <= serialIn;
    else if (strobe.capture) q <= funcIn;
  end

endmodule

// File: rtl/scan_chain_bank.sv
module scan_chain_bank
  import scan_wrap_pkg::*;
#(
  parameter int NUM_FLOPS  = 10,
  parameter int NUM_CHAINS = 3
) (
  input  logic                  clk,
  input  scanStrobe_t           strobe,
  input  logic [NUM_CHAINS-1:0] scanIn,
  output logic [NUM_CHAINS-1:0] scanOut,
  input  logic [NUM_FLOPS-1:0]  funcD,
  output logic [NUM_FLOPS-1:0]  funcQ
);

  localparam int CHAIN_LEN = (NUM_FLOPS + NUM_CHAINS - 1) / NUM_CHAINS;
  localparam int SLOTS     = CHAIN_LEN * NUM_CHAINS;

  // Slot (c, s) lives at c*CHAIN_LEN + s; s = 0 is the scan-in end.
  logic [SLOTS-1:0] slotQ;

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    for (genvar s = 0; s < CHAIN_LEN; s++) begin : g_slot
      localparam int FLOP_IDX = (CHAIN_LEN - 1 - s) * NUM_CHAINS + c;
      logic funcBit;
      logic serialBit;

      if (FLOP_IDX < NUM_FLOPS) begin : g_real
        assign funcBit = funcD[FLOP_IDX];
      end else begin : g_dummy
        assign funcBit = 1'b0;
      end

      if (s == 0) begin : g_head
        assign serialBit = scanIn[c];
      end else begin : g_link
        assign serialBit = slotQ[c*CHAIN_LEN + s - 1];
      end

      scan_cell u_cell (
        .clk      (clk),
        .strobe   (strobe),
        .funcIn   (funcBit),
        .serialIn (serialBit),
        .q        (slotQ[c*CHAIN_LEN + s])
      );
    end

    assign scanOut[c] = slotQ[c*CHAIN_LEN + CHAIN_LEN - 1];
  end

  for (genvar i = 0; i < NUM_FLOPS; i++) begin : g_unstripe
    assign funcQ[i] = slotQ[(i % NUM_CHAINS)*CHAIN_LEN + CHAIN_LEN - 1 - (i / NUM_CHAINS)];
  end

endmodule

// File: rtl/pad_oe_gate.sv
module pad_oe_gate
  import scan_wrap_pkg::*;
#(
  parameter int NUM_PADS = 4
) (
  input  scanStrobe_t         strobe,
  input  logic [NUM_PADS-1:0] padOeReq,
  output logic [NUM_PADS-1:0] padOe
);

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    assign padOe[p] = padOeReq[p] && !strobe.padKill;
  end

endmodule

// File: rtl/scan_wrap.sv
module scan_wrap
  import scan_wrap_pkg::*;
#(
  parameter int NUM_FLOPS  = 10,
  parameter int NUM_CHAINS = 3,
  parameter int NUM_PADS   = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  testMode,
  input  logic [NUM_CHAINS-1:0] scanIn,
  output logic [NUM_CHAINS-1:0] scanOut,
  input  logic [NUM_FLOPS-1:0]  funcD,
  output logic [NUM_FLOPS-1:0]  funcQ,
  input  logic [NUM_PADS-1:0]   padOeReq,
  output logic [NUM_PADS-1:0]   padOe
);

  scanStrobe_t strobe;

  scan_mode_ctrl u_ctrl (
    .rst      (rst),
    .testMode (testMode),
    .strobe   (strobe)
  );

  scan_chain_bank #(
    .NUM_FLOPS  (NUM_FLOPS),
    .NUM_CHAINS (NUM_CHAINS)
  ) u_bank (
    .clk     (clk),
    .strobe  (strobe),
    .scanIn  (scanIn),
    .scanOut (scanOut),
    .funcD   (funcD),
    .funcQ   (funcQ)
  );

  pad_oe_gate #(
    .NUM_PADS (NUM_PADS)
  ) u_pads (
    .strobe   (strobe),
    .padOeReq (padOeReq),
    .padOe    (padOe)
  );

endmodule

// File: rtl/scan_wrap_checker.sv
module scan_wrap_checker #(
  parameter int NUM_FLOPS  = 10,
  parameter int NUM_CHAINS = 3,
  parameter int NUM_PADS   = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  testMode,
  input logic [NUM_CHAINS-1:0] scanIn,
  input logic [NUM_CHAINS-1:0] scanOut,
  input logic [NUM_FLOPS-1:0]  funcD,
  input logic [NUM_FLOPS-1:0]  funcQ,
  input logic [NUM_PADS-1:0]   padOeReq,
  input logic [NUM_PADS-1:0]   padOe
);

  localparam int CHAIN_LEN = (NUM_FLOPS + NUM_CHAINS - 1) / NUM_CHAINS;

  // R1: a functional edge loads the bus
  a_r1_capture: assert property (@(posedge clk) disable iff (rst)
    !testMode |=> funcQ == $past(funcD));

  // R7: pads are off in test mode and follow the request otherwise
  a_r7_pad_off: assert property (@(posedge clk) disable iff (rst)
    testMode |-> padOe == '0);
  a_r7_pad_pass: assert property (@(posedge clk) disable iff (rst)
    !testMode |-> padOe == padOeReq);

  // R8: the first edge after reset shows a cleared bank
  a_r8_cleared: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (funcQ == '0 && scanOut == '0));

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chk
    // R2: the output-end flop takes its neighbour on a shift
    if (CHAIN_LEN > 1 && NUM_CHAINS + c < NUM_FLOPS) begin : g_next
      a_r2_shift: assert property (@(posedge clk) disable iff (rst)
        testMode |=> scanOut[c] == $past(funcQ[NUM_CHAINS + c]));
    end
    // R6: the scan-in-end real flop takes the serial input
    if ((CHAIN_LEN - 1) * NUM_CHAINS + c < NUM_FLOPS) begin : g_head
      a_r6_head_load: assert property (@(posedge clk) disable iff (rst)
        testMode |=> funcQ[(CHAIN_LEN - 1) * NUM_CHAINS + c] == $past(scanIn[c]));
    end
  end

endmodule

bind scan_wrap scan_wrap_checker #(
  .NUM_FLOPS  (NUM_FLOPS),
  .NUM_CHAINS (NUM_CHAINS),
  .NUM_PADS   (NUM_PADS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .testMode (testMode),
  .scanIn   (scanIn),
  .scanOut  (scanOut),
  .funcD    (funcD),
  .funcQ    (funcQ),
  .padOeReq (padOeReq),
  .padOe    (padOe)
);

// File: tb/tb_scan_wrap.sv
`timescale 1ns/1ps
module tb_scan_wrap;

  localparam int N = 10;
  localparam int C = 3;
  localparam int P = 4;
  localparam int L = (N + C - 1) / C;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         testMode = 1'b0;
  logic [C-1:0] scanIn = '0;
  logic [C-1:0] scanOut;
  logic [N-1:0] funcD = '0;
  logic [N-1:0] funcQ;
  logic [P-1:0] padOeReq = '0;
  logic [P-1:0] padOe;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  scan_wrap #(.NUM_FLOPS(N), .NUM_CHAINS(C), .NUM_PADS(P)) dut (
    .clk(clk), .rst(rst), .testMode(testMode), .scanIn(scanIn), .scanOut(scanOut),
    .funcD(funcD), .funcQ(funcQ), .padOeReq(padOeReq), .padOe(padOe)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=<20000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Value of flop idx in a pattern, with dummy slots reading 0.
  function automatic logic bitOf(input logic [N-1:0] pat, input int idx);
    return (idx < N) ? pat[idx] : 1'b0;
  endfunction

  task automatic t_reset();
    rst = 1'b1; testMode = 1'b0; funcD = '1;
    tick();
    check("R8", "funcQ after reset", 32'(funcQ), 32'(0));
    check("R8", "scanOut after reset", 32'(scanOut), 32'(0));
    rst = 1'b0;
  endtask

  task automatic t_capture(input logic [N-1:0] pat);
    testMode = 1'b0; funcD = pat; scanIn = '1;
    tick();
    check("R1", "functional capture", 32'(funcQ), 32'(pat));
    scanIn = '0;
  endtask

  task automatic t_pads();
    testMode = 1'b0; padOeReq = 4'b1011;
    #0.5;
    check("R7", "pads pass in functional mode", 32'(padOe), 32'(4'b1011));
    testMode = 1'b1;
    #0.5;
    check("R7", "pads off in test mode", 32'(padOe), 32'(0));
    testMode = 1'b0;
  endtask

  // Bank holds oldPat; unload it while loading newPat (R4, R6, R9, R2).
  task automatic t_swap(input logic [N-1:0] oldPat, input logic [N-1:0] newPat);
    logic [C-1:0] expOut;
    testMode = 1'b1; padOeReq = '1;
    #0.5;
    for (int c = 0; c < C; c++) expOut[c] = bitOf(oldPat, c);
    check("R4", "scanOut before first shift", 32'(scanOut), 32'(expOut));
    for (int k = 0; k < L; k++) begin
      for (int c = 0; c < C; c++) scanIn[c] = bitOf(newPat, k*C + c);
      funcD = ~funcD;
      tick();
      check("R7", "pads off while shifting", 32'(padOe), 32'(0));
      if (k < L - 1) begin
        for (int c = 0; c < C; c++) expOut[c] = bitOf(oldPat, (k+1)*C + c);
        check("R9", "unload bit during load", 32'(scanOut), 32'(expOut));
      end
    end
    check("R6", "pattern loaded by shifting", 32'(funcQ), 32'(newPat));
    check("R2", "funcD ignored in test mode", 32'(funcQ), 32'(newPat));
    scanIn = '0;
  endtask

  task automatic t_marker();
    rst = 1'b1; tick(); rst = 1'b0;
    testMode = 1'b1; scanIn = '1;
    tick();
    check("R5", "marker after edge 1", 32'(scanOut), (L == 1) ? 32'((1 << C) - 1) : 32'(0));
    scanIn = '0;
    for (int j = 2; j <= L; j++) begin
      tick();
      check("R5", "marker travel", 32'(scanOut), (j == L) ? 32'((1 << C) - 1) : 32'(0));
    end
    testMode = 1'b0;
  endtask

  task automatic t_onehot(input int idx);
    testMode = 1'b0; scanIn = '0;
    funcD = '0; funcD[idx] = 1'b1;
    tick();
    testMode = 1'b1;
    for (int s = 0; s < idx / C; s++) tick();
    #0.5;
    check("R3", $sformatf("flop %0d position", idx), 32'(scanOut), 32'(1 << (idx % C)));
    testMode = 1'b0;
  endtask

  task automatic t_reset_vs_shift();
    testMode = 1'b1; scanIn = '1;
    for (int k = 0; k < L; k++) tick();
    check("R6", "all ones loaded", 32'(funcQ), 32'((1 << N) - 1));
    rst = 1'b1;
    tick();
    check("R8", "reset beats shift funcQ", 32'(funcQ), 32'(0));
    check("R8", "reset beats shift scanOut", 32'(scanOut), 32'(0));
    rst = 1'b0; scanIn = '0; testMode = 1'b0;
  endtask

  initial begin
    #1;
    t_reset();
    t_pads();
    t_capture(10'b10_1100_1011);
    t_swap(10'b10_1100_1011, 10'b01_0110_1101);
    t_capture(10'b11_1111_1111);
    t_swap(10'b11_1111_1111, 10'b00_0000_0000);
    t_capture(10'b01_0101_0101);
    t_swap(10'b01_0101_0101, 10'b10_0000_0001);
    t_marker();
    t_onehot(0);
    t_onehot(4);
    t_onehot(8);
    t_onehot(9);
    t_reset_vs_shift();
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule